// File: doc/BRIEF.md
# Word-Granular Packet Beat Packer

The block accepts packets one 32-bit word at a time and packs them into wide output beats of four 32-bit lanes, with no gaps other than those the framing forces. Each packet is one header word followed by a payload whose length comes with the header as a byte count minus one. Payloads are padded to whole words, so a packet of length code `L` carries `L/4 + 1` payload words (integer division). The end of one packet and the header of the next may share a beat. However, a beat never carries two headers. When a second header would land in a beat that already holds one, the rest of that beat is closed with the idle word and the header moves to lane 0 of the following beat.

Lane 0 (bits 31:0) is the earliest word in a beat, and later words fill the higher lanes. A beat that holds a header raises `out_start` and reports the header's lane and length code beside the data. The output holds still under backpressure. If the source goes quiet at a packet boundary while a beat is partly built, the remaining lanes are filled with the idle word, one per cycle, and the beat is sent. A `gap_req` input lets the system insert idle words between packets on purpose.

Top module: `pkt_beat_packer`

## Requirements
- R1: Words leave in arrival order. Lane 0 (bits 31:0) holds the earliest word of a beat and each later word takes the next higher lane.
- R2: A header accepted with length code `L` (payload bytes minus one) is followed by exactly `L/4 + 1` payload words. The next word flagged `in_sop` after those is taken as a new header.
- R3: When the beat being built holds no header yet, a new header takes the lane right after the previous packet's last word, so that packet's tail and the new head share a beat.
- R4: No beat holds two headers. If a header arrives while the beat already holds one, the unfilled lanes carry `IDLE_WORD` and the header goes to lane 0 of the next beat.
- R5: `out_start` is 1 exactly on beats that contain a header. `out_hdr_lane` then gives that lane (0 to 3) and `out_len` gives its length code. On beats without a header both are 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, all output signals keep their values on the next cycle and `in_ready` stays 0.
- R7: At a packet boundary, with no word offered, no gap requested and a partly built beat, the packer fills one lane per cycle with `IDLE_WORD` until the beat is sent.
- R8: While `gap_req` is 1 at a packet boundary, no header is accepted and one `IDLE_WORD` lane is filled per cycle. From an empty beat, four such cycles give one all-idle beat with `out_start` at 0.
- R9: With no word offered, no gap requested and an empty beat under construction, no beat is produced.
- R10: After reset, `out_valid` and `in_ready` are 0.
- R11: Inside a packet, a cycle without `in_valid` only stalls. No idle word is inserted, and the packet's words stay contiguous in the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Offered word taken this cycle |
| in_sop | input | 1 | Offered word is a packet header |
| in_len | input | 8 | Payload byte count minus one, meaningful with `in_sop` |
| in_data | input | 32 | Input word |
| gap_req | input | 1 | Insert idle words at the next packet boundary |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Sink takes the beat |
| out_data | output | 128 | Beat, lane 0 in bits 31:0 |
| out_start | output | 1 | Beat contains a header |
| out_hdr_lane | output | 2 | Lane index of the header |
| out_len | output | 8 | Length code of the header in this beat |

## Verification
The assertions take for granted that the source raises `in_sop` only on the word that follows a completed packet, never inside a payload, and that header and payload words never equal the idle pattern. The bench builds every header and payload word from a tagged pattern that cannot match `IDLE_WORD`. It derives payload counts from the length code it sends, so `in_sop` marks only real headers. It inserts input bubbles only inside packets, which keeps the expected beat stream independent of the random `out_ready` timing. Boundary idles are exercised only at the end of a stream and in a separate gap phase.

// File: rtl/pkt_pack_pkg.sv
// Package pkt_pack_pkg
// Shared types for the beat packer: the per-cycle action that the controller
// selects and the lane assembler carries out.
package pkt_pack_pkg;

    // One action per advancing cycle; at most one lane is touched per cycle.
    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,  // nothing happens this cycle
        ACT_WORD  = 3'd1,  // place a payload word in the current lane
        ACT_HDR   = 3'd2,  // place a header word in the current lane
        ACT_IDLE  = 3'd3,  // leave the current lane idle and step on
        ACT_CLOSE = 3'd4,  // send the beat with its unfilled lanes idle
        ACT_DROP  = 3'd5   // discard a stray non-header word at a boundary
    } pack_act_e;

endpackage

// File: rtl/pkt_pack_ctrl.sv
// Module pkt_pack_ctrl
// Decides, each cycle, what the lane assembler does, and tracks how many
// payload words of the current packet are still owed.
// Assumes: in_sop marks only words that follow a completed packet; lane
// pointer and header flag come from pkt_lane_fill; adv is high only when
// the output slot can take a beat.
module pkt_pack_ctrl
    import pkt_pack_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adv,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic [LEN_W-1:0]         in_len,
    input  logic                     gap_req,
    input  logic [$clog2(LANES)-1:0] lane_ptr,
    input  logic                     beat_has_hdr,
    output pack_act_e                act,
    output logic                     in_ready
);

    localparam int LANE_IW = $clog2(LANES);
    localparam int CNT_W   = LEN_W - 1;  // holds 2**(LEN_W-2) payload words

    logic [CNT_W-1:0] words_left;
    logic [CNT_W-1:0] hdr_words;
    logic             mid_pkt;

    // Payload words owed by a header with this length code.
    assign hdr_words = CNT_W'(in_len >> 2) + CNT_W'(1);
    assign mid_pkt   = (words_left != '0);

    // Pick this cycle's action from packet position, input and beat state.
    always_comb begin
        act = ACT_NONE;
        if (adv) begin
            if (mid_pkt) begin
                if (in_valid) begin
                    act = ACT_WORD;
                end
            end else if (gap_req) begin
                act = ACT_IDLE;
            end else if (in_valid && in_sop) begin
                act = beat_has_hdr ? ACT_CLOSE : ACT_HDR;
            end else if (in_valid) begin
                act = ACT_DROP;
            end else if (lane_ptr != LANE_IW'(0)) begin
                act = ACT_IDLE;
            end
        end
    end

    // An input word is consumed only by actions that take it.
    assign in_ready = (act == ACT_WORD) || (act == ACT_HDR) || (act == ACT_DROP);

    // Count the remaining payload words of the open packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_left <= '0;
        end else begin
            case (act)
                ACT_HDR:  words_left <= hdr_words;
                ACT_WORD: words_left <= words_left - CNT_W'(1);
                default:  words_left <= words_left;
            endcase
        end
    end

endmodule

// File: rtl/pkt_lane_fill.sv
// Module pkt_lane_fill
// Builds one beat lane by lane. Lanes start out holding the idle word, so
// skipping a lane or closing a beat early needs no write. A beat is handed
// out when its last lane is filled or when the controller closes it.
// Assumes: act is ACT_NONE whenever the output slot cannot take a beat.
module pkt_lane_fill
    import pkt_pack_pkg::*;
#(
    parameter int          LANES     = 4,
    parameter int          WORD_W    = 32,
    parameter int          LEN_W     = 8,
    parameter logic [31:0] IDLE_WORD = 32'h07070707
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  pack_act_e                  act,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [LEN_W-1:0]           hdr_len,
    output logic [$clog2(LANES)-1:0]   lane_ptr,
    output logic                       has_hdr,
    output logic                       emit,
    output logic [LANES*WORD_W-1:0]    emit_data,
    output logic                       emit_start,
    output logic [$clog2(LANES)-1:0]   emit_lane,
    output logic [LEN_W-1:0]           emit_len
);

    localparam int               LANE_IW = $clog2(LANES);
    localparam logic [LANE_IW-1:0] LAST  = LANE_IW'(LANES - 1);
    localparam logic [WORD_W-1:0]  IDLE  = WORD_W'(IDLE_WORD);

    logic [LANE_IW-1:0] hdr_lane;
    logic [LEN_W-1:0]   beat_len;
    logic               fill;
    logic               put_data;

    assign fill     = (act == ACT_WORD) || (act == ACT_HDR) || (act == ACT_IDLE);
    assign put_data = (act == ACT_WORD) || (act == ACT_HDR);
    assign emit     = (fill && (lane_ptr == LAST)) || (act == ACT_CLOSE);

    // Side information of the beat, including a header placed this cycle.
    assign emit_start = has_hdr || (act == ACT_HDR);
    assign emit_lane  = (act == ACT_HDR) ? lane_ptr : hdr_lane;
    assign emit_len   = (act == ACT_HDR) ? hdr_len  : beat_len;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [WORD_W-1:0] stage;
            logic              hit;

            assign hit = fill && (lane_ptr == LANE_IW'(i));
            assign emit_data[i*WORD_W +: WORD_W] = (hit && put_data) ? wdata : stage;

            // Hold this lane's word; return to idle once the beat leaves.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage <= IDLE;
                end else if (emit) begin
                    stage <= IDLE;
                end else if (hit && put_data) begin
                    stage <= wdata;
                end
            end
        end
    endgenerate

    // Track the next free lane and the header carried by the open beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_ptr <= '0;
            has_hdr  <= 1'b0;
            hdr_lane <= '0;
            beat_len <= '0;
        end else if (emit) begin
            lane_ptr <= '0;
            has_hdr  <= 1'b0;
            hdr_lane <= '0;
            beat_len <= '0;
        end else if (fill) begin
            lane_ptr <= lane_ptr + LANE_IW'(1);
            if (act == ACT_HDR) begin
                has_hdr  <= 1'b1;
                hdr_lane <= lane_ptr;
                beat_len <= hdr_len;
            end
        end
    end

endmodule

// File: rtl/pkt_beat_reg.sv
// Module pkt_beat_reg
// Output register for one beat and its side signals. It loads a finished
// beat and keeps it until the sink takes it.
// Assumes: load is raised only while slot_free is high.
module pkt_beat_reg #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [LANES*WORD_W-1:0]    beat_data,
    input  logic                       beat_start,
    input  logic [$clog2(LANES)-1:0]   beat_lane,
    input  logic [LEN_W-1:0]           beat_len,
    input  logic                       out_ready,
    output logic                       slot_free,
    output logic                       out_valid,
    output logic [LANES*WORD_W-1:0]    out_data,
    output logic                       out_start,
    output logic [$clog2(LANES)-1:0]   out_hdr_lane,
    output logic [LEN_W-1:0]           out_len
);

    assign slot_free = !out_valid || out_ready;

    // Valid flag: set by a load, cleared when the sink takes the beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Beat payload and side signals, changed only by a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data     <= '0;
            out_start    <= 1'b0;
            out_hdr_lane <= '0;
            out_len      <= '0;
        end else if (load) begin
            out_data     <= beat_data;
            out_start    <= beat_start;
            out_hdr_lane <= beat_lane;
            out_len      <= beat_len;
        end
    end

endmodule

// File: rtl/pkt_beat_packer.sv
// Module pkt_beat_packer (top)
// Packs a word-wide packet stream into beats of LANES words, with at most
// one header per beat and unused lanes filled with IDLE_WORD.
// Assumes: in_sop is raised only on the word after a completed packet; the
// length code is payload bytes minus one; LANES is a power of two >= 2.
module pkt_beat_packer
    import pkt_pack_pkg::*;
#(
    parameter int          LANES     = 4,
    parameter int          WORD_W    = 32,
    parameter int          LEN_W     = 8,
    parameter logic [31:0] IDLE_WORD = 32'h07070707
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic                       in_sop,
    input  logic [LEN_W-1:0]           in_len,
    input  logic [WORD_W-1:0]          in_data,
    input  logic                       gap_req,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [LANES*WORD_W-1:0]    out_data,
    output logic                       out_start,
    output logic [$clog2(LANES)-1:0]   out_hdr_lane,
    output logic [LEN_W-1:0]           out_len
);

    localparam int LANE_IW = $clog2(LANES);
    localparam int BEAT_W  = LANES * WORD_W;

    pack_act_e          act;
    logic               adv;
    logic [LANE_IW-1:0] lane_ptr;
    logic               has_hdr;
    logic               emit;
    logic [BEAT_W-1:0]  emit_data;
    logic               emit_start;
    logic [LANE_IW-1:0] emit_lane;
    logic [LEN_W-1:0]   emit_len;

    pkt_pack_ctrl #(
        .LANES (LANES),
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (adv),
        .in_valid     (in_valid),
        .in_sop       (in_sop),
        .in_len       (in_len),
        .gap_req      (gap_req),
        .lane_ptr     (lane_ptr),
        .beat_has_hdr (has_hdr),
        .act          (act),
        .in_ready     (in_ready)
    );

    pkt_lane_fill #(
        .LANES     (LANES),
        .WORD_W    (WORD_W),
        .LEN_W     (LEN_W),
        .IDLE_WORD (IDLE_WORD)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .wdata      (in_data),
        .hdr_len    (in_len),
        .lane_ptr   (lane_ptr),
        .has_hdr    (has_hdr),
        .emit       (emit),
        .emit_data  (emit_data),
        .emit_start (emit_start),
        .emit_lane  (emit_lane),
        .emit_len   (emit_len)
    );

    pkt_beat_reg #(
        .LANES  (LANES),
        .WORD_W (WORD_W),
        .LEN_W  (LEN_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (emit),
        .beat_data    (emit_data),
        .beat_start   (emit_start),
        .beat_lane    (emit_lane),
        .beat_len     (emit_len),
        .out_ready    (out_ready),
        .slot_free    (adv),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_start    (out_start),
        .out_hdr_lane (out_hdr_lane),
        .out_len      (out_len)
    );

endmodule

// File: rtl/pkt_beat_packer_chk.sv
// Module pkt_beat_packer_chk
// Port-level properties of the beat packer, attached through bind.
// Assumes: the source obeys the framing described in the top module.
module pkt_beat_packer_chk #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic                       in_sop,
    input logic                       gap_req,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [LANES*WORD_W-1:0]    out_data,
    input logic                       out_start,
    input logic [$clog2(LANES)-1:0]   out_hdr_lane,
    input logic [LEN_W-1:0]           out_len
);

    // R6
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
        $stable(out_start) && $stable(out_hdr_lane) && $stable(out_len)));

    // R6
    no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R5
    idle_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_start) |-> (out_hdr_lane == '0 && out_len == '0));

    // R8
    gap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_req && in_valid && in_sop) |-> !in_ready);

    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind pkt_beat_packer pkt_beat_packer_chk #(
    .LANES  (LANES),
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_sop       (in_sop),
    .gap_req      (gap_req),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_start    (out_start),
    .out_hdr_lane (out_hdr_lane),
    .out_len      (out_len)
);

// File: tb/tb_pkt_beat_packer.sv
// Bench for pkt_beat_packer: sweeps every length code in a scrambled order,
// then runs a dense run of short packets, under random backpressure and
// mid-packet bubbles, and finishes with directed gap and quiet phases.
module tb_pkt_beat_packer;

    localparam int          LANES  = 4;
    localparam int          WORD_W = 32;
    localparam int          LEN_W  = 8;
    localparam logic [31:0] IDLE   = 32'h07070707;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_sop = 1'b0;
    logic [7:0]   in_len = '0;
    logic [31:0]  in_data = '0;
    logic         gap_req = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic         out_start;
    logic [1:0]   out_hdr_lane;
    logic [7:0]   out_len;

    int  n_chk = 0;
    int  n_fail = 0;
    int  beats_seen = 0;
    bit  mon_en = 0;
    bit  rdy_all = 0;
    bit  finished = 0;

    pkt_beat_packer #(
        .LANES (LANES), .WORD_W (WORD_W), .LEN_W (LEN_W), .IDLE_WORD (IDLE)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_sop (in_sop),
        .in_len (in_len), .in_data (in_data), .gap_req (gap_req),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_start (out_start), .out_hdr_lane (out_hdr_lane), .out_len (out_len)
    );

    always #5 clk = ~clk;

    // Expected beats
    logic [127:0] q_data[$];
    bit           q_start[$];
    logic [1:0]   q_lane[$];
    logic [7:0]   q_len[$];

    // Packing model state
    logic [31:0] m_cur [LANES];
    int          m_lane = 0;
    bit          m_has = 0;
    logic [1:0]  m_hl = '0;
    logic [7:0]  m_len = '0;
    int          lens[$];

    task automatic chk(input bit ok, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", what);
        end
    endtask

    function automatic logic [31:0] hdr_word(input int id, input logic [7:0] len);
        return {8'hC0, 8'(id), 8'h00, len};
    endfunction

    function automatic logic [31:0] pay_word(input int id, input int idx);
        return {4'h9, 12'(id), 16'(idx)};
    endfunction

    // Close the model beat: lanes not yet written carry the idle word (R4, R7).
    task automatic m_push();
        logic [127:0] d;
        for (int i = 0; i < LANES; i++) d[i*32 +: 32] = (i < m_lane) ? m_cur[i] : IDLE;
        q_data.push_back(d);
        q_start.push_back(m_has);
        q_lane.push_back(m_has ? m_hl : 2'd0);
        q_len.push_back(m_has ? m_len : 8'd0);
        m_lane = 0;
        m_has = 0;
    endtask

    // Place one word in the model; a second header forces a new beat (R3, R4).
    task automatic m_put(input logic [31:0] w, input bit hdr, input logic [7:0] len);
        if (hdr && m_has) m_push();
        m_cur[m_lane] = w;
        if (hdr) begin
            m_has = 1;
            m_hl  = 2'(m_lane);
            m_len = len;
        end
        m_lane++;
        if (m_lane == LANES) m_push();
    endtask

    // R2: a length code L carries L/4 + 1 payload words.
    task automatic build_stream(input int base);
        for (int p = 0; p < lens.size(); p++) begin
            m_put(hdr_word(base + p, 8'(lens[p])), 1, 8'(lens[p]));
            for (int k = 0; k < lens[p] / 4 + 1; k++) m_put(pay_word(base + p, k), 0, 8'd0);
        end
        if (m_lane > 0) m_push();
    endtask

    task automatic send_word(input logic [31:0] w, input bit sop, input logic [7:0] len);
        bit acc;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        in_sop   = sop;
        in_len   = sop ? len : 8'd0;
        acc = 0;
        while (!acc) begin
            #1;
            acc = in_ready;
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
    endtask

    // R11: bubbles appear only inside packets.
    task automatic drive_stream(input int base);
        for (int p = 0; p < lens.size(); p++) begin
            send_word(hdr_word(base + p, 8'(lens[p])), 1, 8'(lens[p]));
            for (int k = 0; k < lens[p] / 4 + 1; k++) begin
                if ($urandom_range(0, 5) == 0) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    @(posedge clk);
                end
                send_word(pay_word(base + p, k), 0, 8'd0);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    // Monitor: sets backpressure, compares beats, checks holding under stall.
    logic [127:0] s_data;
    logic         s_start;
    logic [1:0]   s_lane;
    logic [7:0]   s_len;
    bit           prev_stall = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (mon_en) begin
                out_ready = rdy_all ? 1'b1 : ($urandom_range(0, 3) != 0);
                #2;
                if (prev_stall) begin
                    // R6: held beat unchanged
                    chk(out_valid && out_data == s_data && out_start == s_start &&
                        out_hdr_lane == s_lane && out_len == s_len,
                        $sformatf("R6 hold act=%0b %h %0b %0d %0d exp=1 %h %0b %0d %0d",
                            out_valid, out_data, out_start, out_hdr_lane, out_len,
                            s_data, s_start, s_lane, s_len));
                end
                prev_stall = out_valid && !out_ready;
                if (prev_stall) begin
                    s_data = out_data; s_start = out_start;
                    s_lane = out_hdr_lane; s_len = out_len;
                    // R6: no input taken while stalled
                    chk(!in_ready, $sformatf("R6 in_ready act=%0b exp=0", in_ready));
                end
                if (out_valid && out_ready) begin
                    beats_seen++;
                    if (q_data.size() == 0) begin
                        chk(0, $sformatf("R9 unexpected beat act=%h exp=none", out_data));
                    end else begin
                        // R1 R2 R3 R4 R5 R7 R8 R11: beat content and side signals
                        chk(out_data == q_data[0] && out_start == q_start[0] &&
                            out_hdr_lane == q_lane[0] && out_len == q_len[0],
                            $sformatf("R1 R3 R4 R5 beat act=%h s%0b l%0d n%0d exp=%h s%0b l%0d n%0d",
                                out_data, out_start, out_hdr_lane, out_len,
                                q_data[0], q_start[0], q_lane[0], q_len[0]));
                        void'(q_data.pop_front());
                        void'(q_start.pop_front());
                        void'(q_lane.pop_front());
                        void'(q_len.pop_front());
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n_before;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R10
        chk(!out_valid, $sformatf("R10 out_valid act=%0b exp=0", out_valid));
        chk(!in_ready, $sformatf("R10 in_ready act=%0b exp=0", in_ready));
        mon_en = 1;

        // Sweep every length code in a scrambled order.
        lens.delete();
        for (int i = 0; i < 256; i++) lens.push_back((i * 37 + 5) % 256);
        build_stream(0);
        drive_stream(0);
        wait (q_data.size() == 0);
        repeat (10) @(posedge clk);

        // Dense short packets: many tail/head shares and header conflicts.
        lens.delete();
        for (int i = 0; i < 96; i++) lens.push_back((i * 5 + i / 7) % 12);
        build_stream(1000);
        drive_stream(1000);
        wait (q_data.size() == 0);
        repeat (10) @(posedge clk);

        // R8: four gap cycles from an empty beat give one all-idle beat.
        rdy_all = 1;
        @(negedge clk);
        q_data.push_back({4{IDLE}});
        q_start.push_back(1'b0);
        q_lane.push_back(2'd0);
        q_len.push_back(8'd0);
        gap_req = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        gap_req = 1'b0;
        repeat (4) @(posedge clk);
        chk(q_data.size() == 0, $sformatf("R8 gap beat pending act=%0d exp=0", q_data.size()));

        // R9: nothing offered, empty beat, no output.
        n_before = beats_seen;
        repeat (20) @(posedge clk);
        chk(beats_seen == n_before, $sformatf("R9 beats act=%0d exp=%0d", beats_seen, n_before));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule